// File: doc/BRIEF.md
# E1 CRC-4 Multiframe Resynchronization Supervisor

This block sits above an E1 doubleframe aligner and keeps track of CRC-4 multiframe alignment. It counts 125 us frames on a frame strobe, confirms multiframe lock when two alignment patterns arrive exactly sixteen frames (2 ms) apart, and reports that lock on a status output. A software control bit lets the host restart only the multiframe search on its rising edge. The doubleframe state is left untouched.

An optional supervision window opens whenever doubleframe lock is regained. If no correctly spaced pair of multiframe patterns is confirmed within 64 frames (8 ms), the block issues a one-cycle request to restart the doubleframe search. A new multiframe search then follows naturally once doubleframe lock returns. Both functions act only while CRC multiframe format is selected.

Top module: `e1_mf_supervisor`

## Requirements
- R1: After reset, `mf_locked`, `mf_restart` and `df_restart` are all 0.
- R2: With `crc_mode`=1 (CRC multiframe format) and `df_locked`=1, a pattern strobe seen after exactly 16 frame strobes since the previous pattern sets `mf_locked` on the next clock edge. It stays set until R4, R6 or R7 clears it.
- R3: A pattern seen after any other number of frame strobes (for example 15 or 17) does not set `mf_locked`. That pattern becomes the new reference for the next spacing check.
- R4: A 0-to-1 transition on `force_ctl` while `crc_mode`=1 produces a single-cycle `mf_restart` pulse on the next edge. On that same edge `mf_locked` clears and the spacing check restarts. A level held at 1, or a 1-to-0 transition, produces no pulse.
- R5: A forced multiframe restart never produces `df_restart`. With the control held high, multiframe lock can be regained by a new correct pair.
- R6: With `crc_mode`=0, `force_ctl` edges, patterns and the auto window have no effect: `mf_restart`, `df_restart` and `mf_locked` all stay 0. An edge on `force_ctl` that happened while `crc_mode` was 0 is not acted on when `crc_mode` returns to 1.
- R7: When `df_locked` is 0, `mf_locked` clears on the next edge and any open supervision window is cancelled. Its frame count restarts from zero when lock returns.
- R8: With `crc_mode`=1 and `auto_en`=1, a 0-to-1 transition on `df_locked` opens a window. If no pair per R2 is confirmed, `df_restart` pulses for exactly one cycle on the edge after the 64th frame strobe of the window. The window then closes, and no further pulse follows.
- R9: A pair confirmed per R2 inside an open window closes it, and no `df_restart` follows.
- R10: With `auto_en`=0, `df_restart` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | One-cycle strobe at every 125 us frame boundary |
| df_locked | input | 1 | Doubleframe alignment held by the aligner |
| mf_pattern | input | 1 | One-cycle strobe for each detected multiframe alignment pattern |
| crc_mode | input | 1 | 1 selects CRC multiframe format |
| force_ctl | input | 1 | Software force-resync bit, acted on at its rising edge |
| auto_en | input | 1 | Enables the 8 ms doubleframe supervision window |
| mf_restart | output | 1 | One-cycle request to restart the multiframe search |
| df_restart | output | 1 | One-cycle request to restart the doubleframe search |
| mf_locked | output | 1 | Multiframe alignment confirmed |

## Verification
The assertions take for granted that a pattern strobe never falls in the same cycle as a frame strobe, so every pattern has a well-defined frame spacing. The stimulus keeps to this by spacing every strobe several clock cycles from any other. It also changes `df_locked`, `crc_mode` and `force_ctl` only in cycles that carry neither strobe. Window and spacing counts are therefore driven purely by the number of frame strobes the bench issues.

// File: rtl/e1mf_pkg.sv
package e1mf_pkg;
  localparam int unsigned FRAMES_2MS = 16;
  localparam int unsigned FRAMES_8MS = 64;

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

  function automatic logic spacing_ok(input int unsigned gap, input int unsigned target);
    return gap == target;
  endfunction

  function automatic logic window_last(input int unsigned cnt, input int unsigned len);
    return cnt == len - 1;
  endfunction
endpackage

// File: rtl/mf_force_edge.sv
module mf_force_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic force_ctl,
  input  logic crc_mode,
  output logic force_rise
);
  logic force_q;

  always_ff @(posedge clk) begin
    if (!rst_n) force_q <= 1'b0;
    else        force_q <= force_ctl;
  end

  assign force_rise = force_ctl && !force_q && crc_mode;
endmodule

// File: rtl/mf_pair_tracker.sv
module mf_pair_tracker #(
  parameter int unsigned GAP = e1mf_pkg::FRAMES_2MS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic clear,
  input  logic frame_tick,
  input  logic pattern,
  output logic pair_ok,
  output logic locked
);
  import e1mf_pkg::*;
  localparam int unsigned GW  = cnt_width(GAP + 1);
  localparam int unsigned SAT = GAP + 1;

  logic          have_ref;
  logic [GW-1:0] gap_cnt;

  assign pair_ok = enable && !clear && pattern && have_ref &&
                   spacing_ok(int'(gap_cnt), GAP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_ref <= 1'b0;
      gap_cnt  <= '0;
      locked   <= 1'b0;
    end else if (!enable || clear) begin
      have_ref <= 1'b0;
      gap_cnt  <= '0;
      locked   <= 1'b0;
    end else if (pattern) begin
      have_ref <= 1'b1;
      gap_cnt  <= '0;
      if (pair_ok) locked <= 1'b1;
    end else if (frame_tick && have_ref && (int'(gap_cnt) < SAT)) begin
      gap_cnt <= gap_cnt + 1'b1;
    end
  end

  assert_pattern_off_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(pattern && frame_tick));
  assert_lock_needs_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(pair_ok));
  assert_lockloss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !locked);
endmodule

// File: rtl/df_window_watch.sv
module df_window_watch #(
  parameter int unsigned WIN = e1mf_pkg::FRAMES_8MS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_en,
  input  logic df_locked,
  input  logic frame_tick,
  input  logic pair_ok,
  output logic df_restart
);
  import e1mf_pkg::*;
  localparam int unsigned CW = cnt_width(WIN);

  logic          df_q;
  logic          active;
  logic [CW-1:0] win_cnt;
  logic          df_rise;
  logic          expire;

  assign df_rise = df_locked && !df_q;
  assign expire  = active && frame_tick && !pair_ok && window_last(int'(win_cnt), WIN);

  always_ff @(posedge clk) begin
    if (!rst_n) df_q <= 1'b0;
    else        df_q <= df_locked;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active     <= 1'b0;
      win_cnt    <= '0;
      df_restart <= 1'b0;
    end else begin
      df_restart <= 1'b0;
      if (!arm_en || !df_locked) begin
        active  <= 1'b0;
        win_cnt <= '0;
      end else if (df_rise) begin
        active  <= 1'b1;
        win_cnt <= '0;
      end else if (active && pair_ok) begin
        active  <= 1'b0;
        win_cnt <= '0;
      end else if (expire) begin
        df_restart <= 1'b1;
        active     <= 1'b0;
        win_cnt    <= '0;
      end else if (active && frame_tick) begin
        win_cnt <= win_cnt + 1'b1;
      end
    end
  end

  assert_restart_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    df_restart |=> !df_restart);
  assert_window_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(win_cnt) < WIN);
  assert_no_restart_disarmed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    df_restart |-> $past(arm_en));
endmodule

// File: rtl/e1_mf_supervisor.sv
module e1_mf_supervisor #(
  parameter int unsigned GAP = e1mf_pkg::FRAMES_2MS,
  parameter int unsigned WIN = e1mf_pkg::FRAMES_8MS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_tick,
  input  logic df_locked,
  input  logic mf_pattern,
  input  logic crc_mode,
  input  logic force_ctl,
  input  logic auto_en,
  output logic mf_restart,
  output logic df_restart,
  output logic mf_locked
);
  logic force_rise;
  logic pair_ok;
  logic track_en;
  logic arm_en;

  assign track_en = crc_mode && df_locked;
  assign arm_en   = crc_mode && auto_en;

  mf_force_edge u_edge (
    .clk(clk), .rst_n(rst_n), .force_ctl(force_ctl),
    .crc_mode(crc_mode), .force_rise(force_rise)
  );

  mf_pair_tracker #(.GAP(GAP)) u_pair (
    .clk(clk), .rst_n(rst_n), .enable(track_en), .clear(force_rise),
    .frame_tick(frame_tick), .pattern(mf_pattern),
    .pair_ok(pair_ok), .locked(mf_locked)
  );

  df_window_watch #(.WIN(WIN)) u_watch (
    .clk(clk), .rst_n(rst_n), .arm_en(arm_en), .df_locked(df_locked),
    .frame_tick(frame_tick), .pair_ok(pair_ok), .df_restart(df_restart)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) mf_restart <= 1'b0;
    else        mf_restart <= force_rise;
  end

  assert_restart_drops_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mf_restart |-> !mf_locked);
  assert_restart_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mf_restart |=> !mf_restart);
  assert_restart_needs_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mf_restart |-> $past(crc_mode));
endmodule

// File: tb/e1_mf_supervisor_bench.sv
module e1_mf_supervisor_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_tick = 1'b0, df_locked = 1'b0, mf_pattern = 1'b0;
  logic crc_mode = 1'b0, force_ctl = 1'b0, auto_en = 1'b0;
  logic mf_restart, df_restart, mf_locked;

  always #(CLK_PERIOD/2) clk = ~clk;

  e1_mf_supervisor u_e1_mf_supervisor (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .df_locked(df_locked),
    .mf_pattern(mf_pattern), .crc_mode(crc_mode), .force_ctl(force_ctl),
    .auto_en(auto_en), .mf_restart(mf_restart), .df_restart(df_restart),
    .mf_locked(mf_locked)
  );

  typedef struct {
    int    kind;
    int    exp;
    string tag;
  } item_t;

  item_t q[$];
  int tests = 0, fails = 0;
  int n_mfr = 0, n_dfr = 0;
  int exp_mfr = 0, exp_dfr = 0;
  bit done = 0;

  // monitor: counts pulses and compares queued expectations
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (mf_restart) n_mfr++;
      if (df_restart) n_dfr++;
      while (q.size() > 0) begin
        item_t it;
        int act;
        it = q.pop_front();
        act = (it.kind == 0) ? int'(mf_locked) : (it.kind == 1) ? n_mfr : n_dfr;
        tests++;
        if (act != it.exp) begin
          fails++;
          $display("FAIL %s: actual %0d expected %0d", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic expect_val(input int kind, input int exp, input string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); frame_tick = 1'b1;
      @(negedge clk); frame_tick = 1'b0;
      step(2);
    end
  endtask

  task automatic pattern();
    @(negedge clk); mf_pattern = 1'b1;
    @(negedge clk); mf_pattern = 1'b0;
  endtask

  task automatic df_cycle();
    @(negedge clk); df_locked = 1'b0;
    step(2);
    df_locked = 1'b1;
    step(2);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);
    // R1
    expect_val(0, 0, "R1 lock after reset");
    expect_val(1, 0, "R1 mf_restart after reset");
    expect_val(2, 0, "R1 df_restart after reset");

    // R2
    crc_mode = 1'b1; df_locked = 1'b1; step(2);
    pattern(); ticks(16); pattern();
    expect_val(0, 1, "R2 lock on 16-frame pair");

    // R7 lock loss
    @(negedge clk); df_locked = 1'b0; step(2);
    expect_val(0, 0, "R7 lock cleared by doubleframe loss");
    df_locked = 1'b1; step(2);

    // R3
    pattern(); ticks(15); pattern();
    expect_val(0, 0, "R3 15-frame spacing rejected");
    ticks(16); pattern();
    expect_val(0, 1, "R3 latest pattern is new reference");

    // R4 / R5
    @(negedge clk); force_ctl = 1'b1; step(3);
    exp_mfr++;
    expect_val(1, exp_mfr, "R4 rising edge pulses mf_restart");
    expect_val(0, 0, "R4 lock cleared by force");
    expect_val(2, exp_dfr, "R5 no doubleframe restart from force");
    ticks(20);
    expect_val(1, exp_mfr, "R4 held level has no effect");
    pattern(); ticks(16); pattern();
    expect_val(0, 1, "R5 relock with control held high");
    @(negedge clk); force_ctl = 1'b0; step(3);
    expect_val(1, exp_mfr, "R4 falling edge has no effect");
    expect_val(0, 1, "R4 falling edge keeps lock");
    @(negedge clk); force_ctl = 1'b1; step(3);
    exp_mfr++;
    expect_val(1, exp_mfr, "R4 second rising edge");

    // R3 long spacing
    pattern(); ticks(17); pattern();
    expect_val(0, 0, "R3 17-frame spacing rejected");
    ticks(16); pattern();
    expect_val(0, 1, "R3 relock after long spacing");

    // R6
    @(negedge clk); crc_mode = 1'b0; step(2);
    expect_val(0, 0, "R6 lock dropped outside CRC mode");
    force_ctl = 1'b0; step(2); force_ctl = 1'b1; step(3);
    expect_val(1, exp_mfr, "R6 force edge ignored");
    pattern(); ticks(16); pattern();
    expect_val(0, 0, "R6 patterns ignored");
    auto_en = 1'b1; df_cycle(); ticks(70);
    expect_val(2, exp_dfr, "R6 auto window ignored");
    @(negedge clk); crc_mode = 1'b1; step(3);
    expect_val(1, exp_mfr, "R6 stale force edge not acted on");

    // R8
    df_cycle(); ticks(63);
    expect_val(2, exp_dfr, "R8 no restart before 64th frame");
    ticks(1);
    exp_dfr++;
    expect_val(2, exp_dfr, "R8 restart after 64th frame");
    ticks(70);
    expect_val(2, exp_dfr, "R8 single restart per window");

    // R9
    df_cycle(); pattern(); ticks(16); pattern();
    expect_val(0, 1, "R9 pair inside window locks");
    ticks(80);
    expect_val(2, exp_dfr, "R9 pair closes window");

    // R7 window cancel
    df_cycle(); ticks(40);
    df_cycle(); ticks(40);
    expect_val(2, exp_dfr, "R7 window restarted by lock loss");
    ticks(24);
    exp_dfr++;
    expect_val(2, exp_dfr, "R7 restarted window expires on its own count");

    // R10
    @(negedge clk); auto_en = 1'b0;
    df_cycle(); ticks(70);
    expect_val(2, exp_dfr, "R10 auto disabled");

    step(3);
    done = 1;
    summary();
    $finish;
  end
endmodule